// File: doc/BRIEF.md
# Windowed Tone-Burst Generator

This block produces a finite, envelope-shaped sine burst as a signed sample stream for a DAC that feeds a piezoelectric transducer. A host sets four values: a 32-bit phase increment that fixes the tone frequency relative to the sample clock, the number of whole tone periods, an amplitude in percent of full scale and an envelope shape. A single-cycle start pulse then launches the burst. The block emits one sample per clock until the programmed number of periods is complete, and afterwards returns to a quiet mid-scale zero.

A phase accumulator addresses a sine table. A second accumulator, whose step is the phase step divided by the period count, addresses the envelope table, so that the envelope covers the burst from its first sample to its last. For a 100 MHz sample clock, increments between about 1.29e6 and 4.29e7 cover 30 kHz to 1 MHz. The time from start to the first sample does not depend on any setting. Several instances that share one start line therefore emit together.

Top module: `burst_synth`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `busy`, `dac_valid` and `dac_data` are all zero.
- R2: `start` is taken only while `busy` is low. A pulse that arrives while `busy` is high changes neither the running burst nor any later output.
- R3: Sample n of a burst uses phase p = n*phase_inc mod 2^32. Its sine value is round(32767*sin(2*pi*k/256)), where k is bits 31..24 of p.
- R4: A burst emits exactly ceil(P*2^32/phase_inc) samples, one per clock with no gap, where P is `periods` and a value of 0 counts as 1.
- R5: The envelope index is bits 31..26 of m = n*floor(phase_inc/P) mod 2^32. The envelope value is round(32767*(a0 - a1*cos(2*pi*j/64) + a2*cos(4*pi*j/64))), with (a0,a1,a2) set by `shape`: 0 = (1,0,0) flat, 1 = (0.5,0.5,0) Hann, 2 = (0.54,0.46,0) Hamming, 3 = (0.42,0.5,0.08) Blackman.
- R6: The gain is 32768 when `amp_pct` is 100 or more, and floor(amp_pct*32768/100) otherwise. A gain of 0 gives an all-zero burst.
- R7: `dac_data` = floor((s*w*g + 2^33) / 2^34) as 12-bit two's complement, limited to at most +2047, where s, w and g are the sine value, the envelope value and the gain.
- R8: Whenever `dac_valid` is low, `dac_data` is zero.
- R9: `busy` rises on the clock edge that takes `start`, stays high through the last valid sample and falls on the next edge.
- R10: The first sample of every burst is valid exactly 34 clock edges after the edge that takes `start`, whatever the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst trigger, one cycle |
| phase_inc | input | 32 | Phase step per sample |
| periods | input | 8 | Tone periods per burst (0 counts as 1) |
| amp_pct | input | 8 | Amplitude in percent of full scale |
| shape | input | 2 | Envelope select: 0 flat, 1 Hann, 2 Hamming, 3 Blackman |
| busy | output | 1 | Burst in progress |
| dac_valid | output | 1 | Sample strobe |
| dac_data | output | 12 | Signed sample, two's complement |

## Verification
The hardest condition to create is a second trigger that arrives in the middle of a burst and carries different settings. A correct design must ignore it. The driver raises such a pulse fifty cycles into a five-period Hamming burst, with other frequency, shape and gain values on the inputs. The scoreboard then confirms that every remaining sample and the sample count still match the first set of settings, and that `busy` stays low afterwards. The output limit is reached by a flat envelope at full gain, where the peak of the sine rounds to 2048 and must be held at 2047.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    WIN_FLAT  = 2'd0,
    WIN_HANN  = 2'd1,
    WIN_HAMM  = 2'd2,
    WIN_BLACK = 2'd3
  } win_shape_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_RUN  = 2'd2
  } burst_st_e;

  localparam real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/burst_div.sv
// Restoring divider, one quotient bit per clock. Yields the envelope step.
module burst_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q, q_d;
  logic [DEN_W-1:0] r_q, r_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   trial;
  logic [DEN_W-1:0] den_q, den_d;

  always_comb begin
    q_d    = q_q;
    r_d    = r_q;
    cnt_d  = cnt_q;
    den_d  = den_q;
    done_d = 1'b0;
    trial  = {r_q, q_q[NUM_W-1]};
    if (go) begin
      q_d   = num;
      r_d   = '0;
      den_d = den;
      cnt_d = CW'(NUM_W);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        r_d = DEN_W'(trial - {1'b0, den_q});
        q_d = {q_q[NUM_W-2:0], 1'b1};
      end else begin
        r_d = trial[DEN_W-1:0];
        q_d = {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      den_q  <= '0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      r_q    <= r_d;
      cnt_q  <= cnt_d;
      den_q  <= den_d;
      done_q <= done_d;
    end
  end

  assign quo  = q_q;
  assign done = done_q;
endmodule

// File: rtl/burst_rom.sv
// Sine and envelope tables, filled at elaboration from closed-form formulas.
module burst_rom #(
  parameter int SIN_AW = 8,
  parameter int WIN_AW = 6,
  parameter int SMP_W  = 16
) (
  input  logic [SIN_AW-1:0]       sin_idx,
  input  logic [WIN_AW-1:0]       win_idx,
  input  logic [1:0]              shape,
  output logic signed [SMP_W-1:0] sin_val,
  output logic [SMP_W-1:0]        win_val
);
  import burst_pkg::*;

  localparam int  SIN_N = 1 << SIN_AW;
  localparam int  WIN_N = 1 << WIN_AW;
  localparam real FS    = real'((1 << (SMP_W - 1)) - 1);

  logic signed [SMP_W-1:0] sin_tab [SIN_N];
  logic [SMP_W-1:0]        win_tab [4][WIN_N];

  for (genvar i = 0; i < SIN_N; i++) begin : g_sin
    localparam int V = $rtoi($floor(FS * $sin(TWO_PI * real'(i) / real'(SIN_N)) + 0.5));
    assign sin_tab[i] = SMP_W'(V);
  end

  for (genvar s = 0; s < 4; s++) begin : g_shape
    localparam real A0 = (s == 0) ? 1.0 : (s == 1) ? 0.5 : (s == 2) ? 0.54 : 0.42;
    localparam real A1 = (s == 0) ? 0.0 : (s == 1) ? 0.5 : (s == 2) ? 0.46 : 0.5;
    localparam real A2 = (s == 3) ? 0.08 : 0.0;
    for (genvar j = 0; j < WIN_N; j++) begin : g_pt
      localparam real C1 = $cos(TWO_PI * real'(j) / real'(WIN_N));
      localparam real C2 = $cos(2.0 * TWO_PI * real'(j) / real'(WIN_N));
      localparam int  V  = $rtoi($floor(FS * (A0 - A1 * C1 + A2 * C2) + 0.5));
      assign win_tab[s][j] = SMP_W'(V);
    end
  end

  assign sin_val = sin_tab[sin_idx];
  assign win_val = win_tab[shape][win_idx];
endmodule

// File: rtl/burst_synth.sv
module burst_synth #(
  parameter int PHASE_W = 32,
  parameter int CNT_W   = 8,
  parameter int PCT_W   = 8,
  parameter int SIN_AW  = 8,
  parameter int WIN_AW  = 6,
  parameter int SMP_W   = 16,
  parameter int OUT_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PHASE_W-1:0]      phase_inc,
  input  logic [CNT_W-1:0]        periods,
  input  logic [PCT_W-1:0]        amp_pct,
  input  logic [1:0]              shape,
  output logic                    busy,
  output logic                    dac_valid,
  output logic signed [OUT_W-1:0] dac_data
);
  import burst_pkg::*;

  localparam int GAIN_W = SMP_W + 1;
  localparam int FULL_GAIN = 1 << (SMP_W - 1);
  localparam int PS_W   = PCT_W + SMP_W - 1;
  localparam int PROD_W = 3 * SMP_W + 2;
  localparam int SHIFT  = 2 * (SMP_W - 1) + (SMP_W - OUT_W);
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (SHIFT - 1);
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  burst_st_e          st_q, st_d;
  logic [PHASE_W-1:0] inc_q, inc_d, phase_q, phase_d, win_q, win_d, winc_q, winc_d;
  logic [CNT_W-1:0]   per_q, per_d, wraps_q, wraps_d, eff_per;
  logic [GAIN_W-1:0]  gain_q, gain_d, gain_calc;
  logic [1:0]         shape_q, shape_d;
  logic               wrap_c, go, cfg_ld;
  logic [PS_W-1:0]    pct_scaled;
  logic [PHASE_W-1:0] div_quo;
  logic               div_done;

  assign go      = start & ~busy;
  assign cfg_ld  = go & (st_q == ST_IDLE);
  assign eff_per = (periods == '0) ? CNT_W'(1) : periods;
  assign pct_scaled = {amp_pct, {(SMP_W-1){1'b0}}};
  assign gain_calc  = (amp_pct >= PCT_W'(100)) ? GAIN_W'(FULL_GAIN)
                                               : GAIN_W'(pct_scaled / PS_W'(100));

  burst_div #(.NUM_W(PHASE_W), .DEN_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .go(cfg_ld), .num(phase_inc), .den(eff_per),
    .quo(div_quo), .done(div_done)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;   inc_d = inc_q;     per_d = per_q;     gain_d = gain_q;
    shape_d = shape_q; phase_d = phase_q; win_d = win_q; winc_d = winc_q;
    wraps_d = wraps_q; wrap_c = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cfg_ld) begin
        inc_d = phase_inc; per_d = eff_per; gain_d = gain_calc; shape_d = shape;
        st_d  = ST_DIV;
      end
      ST_DIV: if (div_done) begin
        winc_d = div_quo; phase_d = '0; win_d = '0; wraps_d = '0;
        st_d   = ST_RUN;
      end
      ST_RUN: begin
        {wrap_c, phase_d} = {1'b0, phase_q} + {1'b0, inc_q};
        win_d = win_q + winc_q;
        if (wrap_c) begin
          wraps_d = wraps_q + 1'b1;
          if (wraps_d == per_q) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q <= ST_IDLE; inc_q <= '0; per_q <= '0; gain_q <= '0; shape_q <= '0;
      phase_q <= '0; win_q <= '0; winc_q <= '0; wraps_q <= '0;
    end else begin
      st_q <= st_d; inc_q <= inc_d; per_q <= per_d; gain_q <= gain_d; shape_q <= shape_d;
      phase_q <= phase_d; win_q <= win_d; winc_q <= winc_d; wraps_q <= wraps_d;
    end
  end

  // datapath: sine x envelope x gain, rounded and limited
  logic signed [SMP_W-1:0]  sin_val;
  logic [SMP_W-1:0]         win_val;
  logic signed [PROD_W-1:0] sx, wx, gx, prod, scaled;
  logic signed [OUT_W-1:0]  data_d, data_q;
  logic                     vld_d, vld_q;

  burst_rom #(.SIN_AW(SIN_AW), .WIN_AW(WIN_AW), .SMP_W(SMP_W)) u_rom (
    .sin_idx(phase_q[PHASE_W-1 -: SIN_AW]), .win_idx(win_q[PHASE_W-1 -: WIN_AW]),
    .shape(shape_q), .sin_val(sin_val), .win_val(win_val)
  );

  always_comb begin
    sx     = {{(PROD_W-SMP_W){sin_val[SMP_W-1]}}, sin_val};
    wx     = {{(PROD_W-SMP_W){1'b0}}, win_val};
    gx     = {{(PROD_W-GAIN_W){1'b0}}, gain_q};
    prod   = sx * wx * gx;
    scaled = (prod + HALF) >>> SHIFT;
    vld_d  = (st_q == ST_RUN);
    if (!vld_d)             data_d = '0;
    else if (scaled > MAXV) data_d = OUT_W'(MAXV);
    else if (scaled < MINV) data_d = OUT_W'(MINV);
    else                    data_d = OUT_W'(scaled);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign busy      = (st_q != ST_IDLE) | vld_q;
  assign dac_valid = vld_q;
  assign dac_data  = data_q;
endmodule

// File: rtl/burst_synth_chk.sv
module burst_synth_chk #(
  parameter int OUT_W  = 12,
  parameter int GAIN_W = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    dac_valid,
  input logic signed [OUT_W-1:0] dac_data,
  input logic [GAIN_W-1:0]       gain
);
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> dac_data == '0);

  assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> busy);

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_busy_ends_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dac_valid));

  assert_stream_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_valid) |-> !busy);

  assert_zero_gain_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && $past(gain) == '0) |-> dac_data == '0);
endmodule

bind burst_synth burst_synth_chk #(.OUT_W(OUT_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .dac_valid(dac_valid), .dac_data(dac_data), .gain(gain_q)
);

// File: tb/sim_burst_synth.sv
module sim_burst_synth;
  localparam int  CLK_PERIOD = 10;
  localparam int  LATENCY    = 34;
  localparam real TWO_PI     = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [31:0]        phase_inc;
  logic [7:0]         periods, amp_pct;
  logic [1:0]         shape;
  logic               busy, dac_valid;
  logic signed [11:0] dac_data;

  burst_synth u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_inc(phase_inc), .periods(periods),
    .amp_pct(amp_pct), .shape(shape), .busy(busy), .dac_valid(dac_valid), .dac_data(dac_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_checks = 0, n_errors = 0;
  int     exp_q[$];
  longint cyc = 0, start_cyc = 0;
  bit     mon_on = 1'b0, prev_vld = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sin_ref(input int k);
    return $rtoi($floor(32767.0 * $sin(TWO_PI * real'(k) / 256.0) + 0.5));
  endfunction

  function automatic int win_ref(input int sh, input int j);
    real a0, a1, a2;
    a0 = (sh == 0) ? 1.0 : (sh == 1) ? 0.5 : (sh == 2) ? 0.54 : 0.42;
    a1 = (sh == 0) ? 0.0 : (sh == 1) ? 0.5 : (sh == 2) ? 0.46 : 0.5;
    a2 = (sh == 3) ? 0.08 : 0.0;
    return $rtoi($floor(32767.0 * (a0 - a1 * $cos(TWO_PI * real'(j) / 64.0)
                        + a2 * $cos(2.0 * TWO_PI * real'(j) / 64.0)) + 0.5));
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // monitor: pops expected samples as the design delivers them
  always @(negedge clk) begin
    if (mon_on) begin
      if (dac_valid) begin
        chk(busy, "R9 busy during sample", busy, 1);
        if (!prev_vld) chk(cyc - start_cyc == LATENCY, "R10 first-sample latency",
                           cyc - start_cyc, LATENCY);
        if (exp_q.size() == 0) chk(1'b0, "R4 extra sample", dac_data, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(dac_data) == e, "R3/R5/R7 sample value", dac_data, e);
        end
      end else begin
        chk(dac_data == '0, "R8 idle output", dac_data, 0);
        if (prev_vld) chk(!busy, "R9 busy after last sample", busy, 0);
      end
    end
    prev_vld = dac_valid;
  end

  // driver: computes the expected burst, then triggers it
  task automatic run_burst(input logic [31:0] inc, input int per, input int pct,
                           input int sh, input bit poke);
    longint p_eff, lim, winc, g;
    p_eff = (per == 0) ? 1 : per;
    lim   = p_eff <<< 32;
    winc  = longint'(inc) / p_eff;
    g     = (pct >= 100) ? 32768 : (longint'(pct) * 32768) / 100;
    for (longint n = 0; n * longint'(inc) < lim; n++) begin
      longint ph, wp, pr, r;
      ph = (n * longint'(inc)) & 64'hFFFF_FFFF;
      wp = (n * winc) & 64'hFFFF_FFFF;
      pr = longint'(sin_ref(int'(ph >> 24))) * longint'(win_ref(sh, int'(wp >> 26))) * g;
      r  = (pr + (64'sd1 <<< 33)) >>> 34;
      if (r > 2047) r = 2047;
      exp_q.push_back(int'(r));
    end
    phase_inc = inc; periods = 8'(per); amp_pct = 8'(pct); shape = 2'(sh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    chk(busy, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      phase_inc = 32'h0100_0000; periods = 8'd9; amp_pct = 8'd100; shape = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R4 sample count", exp_q.size(), 0);
    exp_q.delete();
    repeat (40) @(negedge clk);
    chk(!busy, "R2 no restart from ignored pulse", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; phase_inc = '0; periods = '0; amp_pct = '0; shape = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !dac_valid && dac_data == '0, "R1 reset state", {busy, dac_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !dac_valid && dac_data == '0, "R1 after release", {busy, dac_valid}, 0);
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    run_burst(32'h0400_0000, 1, 100, 0, 1'b0);  // R7 limit at the sine peak, flat
    run_burst(32'd107374182, 3, 50, 1, 1'b0);   // R5 Hann, R6 half gain
    run_burst(32'h0800_0000, 5, 75, 2, 1'b1);   // R2 pulse during busy, Hamming
    run_burst(32'h0300_0000, 2, 150, 3, 1'b0);  // R6 above 100 saturates, Blackman
    run_burst(32'h0800_0000, 0, 0, 0, 1'b0);    // R4 zero periods as one, R6 zero gain
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule